// File: doc/BRIEF.md
# Interrupt Eligibility Mask Unit

This block takes the per-interrupt state of one bank of interrupt lines and decides which of them may be offered to a processor interface. Each lane has a sticky request bit and a trigger-mode bit (edge or level). It also has the live input level, an enable, an in-service (active) flag, a group bit and a group-qualifier bit. A shared control word adds a security-collapse bit and three independent group gates. Every lane is evaluated in parallel with the others. The resulting mask is captured in a register on each clock.

A priority selector downstream consumes the mask and never sees the raw state. Storage of the bitmaps and their register access are held elsewhere in the chip.

Top module: `irq_elig_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, `elig_mask` becomes all zero after that edge.
- R2: A lane whose `req_latch` bit is 1, with `irq_en` 1, `irq_act` 0 and its group gate open, shows 1 in `elig_mask` one clock after the inputs are applied.
- R3: With `trig_edge` 0 (level mode), a high `line_lvl` makes the lane a candidate even with `req_latch` 0. With `trig_edge` 1 (edge mode), a high `line_lvl` alone does not.
- R4: A lane with `irq_en` 0 is never set in `elig_mask`.
- R5: A lane with `irq_act` 1 is never set in `elig_mask`.
- R6: A lane with `grp_sel` 1 (non-secure group 1) passes only while `gate_g1ns` is 1.
- R7: With `sec_off` 0, a lane with `grp_sel` 0 and `grp_qual` 1 (secure group 1) passes only while `gate_g1s` is 1.
- R8: A lane with `grp_sel` 0 and `grp_qual` 0 (group 0) passes only while `gate_g0` is 1.
- R9: With `sec_off` 1, every `grp_qual` bit is treated as 0. Every lane with `grp_sel` 0 then follows `gate_g0`, and `gate_g1s` has no effect on the mask.
- R10: Lanes are independent. Each bit of `elig_mask` depends only on the inputs of that lane and on the shared control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_latch | input | LANES | Sticky pending request per lane |
| trig_edge | input | LANES | Trigger mode, 1 = edge, 0 = level |
| line_lvl | input | LANES | Current input line level |
| irq_en | input | LANES | Per-lane enable |
| irq_act | input | LANES | Per-lane active (in service) flag |
| grp_sel | input | LANES | Group bit, 1 = non-secure group 1 |
| grp_qual | input | LANES | Group qualifier, selects secure group 1 when group bit is 0 |
| sec_off | input | 1 | Security collapse, forces qualifiers to zero |
| gate_g1ns | input | 1 | Enable for non-secure group 1 |
| gate_g1s | input | 1 | Enable for secure group 1 |
| gate_g0 | input | 1 | Enable for group 0 |
| elig_mask | output | LANES | Registered eligibility mask |

## Verification
The bench builds the block with the default of 32 lanes, which matches a full bank, so the top and bottom lanes and all of the lanes between them are reachable in one vector. With that width, the bench uses walking-one and alternating patterns to show that lanes are independent. It also sweeps all sixteen combinations of the four control bits against mixed group and qualifier patterns. This reaches every group path, and also the collapse of the secure group when the security bit is set.

// File: rtl/elig_pkg.sv
package elig_pkg;

    // Shared control word from the distributor
    typedef struct packed {
        logic sec_off;
        logic gate_g1ns;
        logic gate_g1s;
        logic gate_g0;
    } elig_ctl_t;

endpackage

// File: rtl/elig_cand.sv
module elig_cand #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] req_latch,
    input  logic [LANES-1:0] trig_edge,
    input  logic [LANES-1:0] line_lvl,
    input  logic [LANES-1:0] irq_en,
    input  logic [LANES-1:0] irq_act,
    output logic [LANES-1:0] cand
);
    logic [LANES-1:0] lvl_hit;

    // A level-mode lane with a high line counts as requesting
    assign lvl_hit = ~trig_edge & line_lvl;

    always_comb begin
        cand = (req_latch | lvl_hit) & irq_en & ~irq_act;
    end
endmodule

// File: rtl/elig_grp_filter.sv
module elig_grp_filter
    import elig_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] grp_sel,
    input  logic [LANES-1:0] grp_qual,
    input  elig_ctl_t        ctl,
    output logic [LANES-1:0] grp_ok
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic qual_eff;
        logic is_g1ns;
        logic is_g1s;
        logic is_g0;

        always_comb begin
            qual_eff = grp_qual[i] & ~ctl.sec_off;
            is_g1ns  = grp_sel[i];
            is_g1s   = ~grp_sel[i] & qual_eff;
            is_g0    = ~grp_sel[i] & ~qual_eff;
            grp_ok[i] = (is_g1ns & ctl.gate_g1ns)
                      | (is_g1s  & ctl.gate_g1s)
                      | (is_g0   & ctl.gate_g0);
        end
    end
endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
    import elig_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] req_latch,
    input  logic [LANES-1:0] trig_edge,
    input  logic [LANES-1:0] line_lvl,
    input  logic [LANES-1:0] irq_en,
    input  logic [LANES-1:0] irq_act,
    input  logic [LANES-1:0] grp_sel,
    input  logic [LANES-1:0] grp_qual,
    input  logic             sec_off,
    input  logic             gate_g1ns,
    input  logic             gate_g1s,
    input  logic             gate_g0,
    output logic [LANES-1:0] elig_mask
);
    typedef struct packed {
        logic [LANES-1:0] mask;
    } bank_state_t;

    bank_state_t      st_d;
    bank_state_t      st_q;
    elig_ctl_t        ctl;
    logic [LANES-1:0] cand;
    logic [LANES-1:0] grp_ok;

    assign ctl = '{sec_off: sec_off, gate_g1ns: gate_g1ns,
                   gate_g1s: gate_g1s, gate_g0: gate_g0};

    elig_cand #(.LANES(LANES)) i_cand (
        .req_latch (req_latch),
        .trig_edge (trig_edge),
        .line_lvl  (line_lvl),
        .irq_en    (irq_en),
        .irq_act   (irq_act),
        .cand      (cand)
    );

    elig_grp_filter #(.LANES(LANES)) i_grp (
        .grp_sel  (grp_sel),
        .grp_qual (grp_qual),
        .ctl      (ctl),
        .grp_ok   (grp_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = cand & grp_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign elig_mask = st_q.mask;
endmodule

// File: rtl/irq_elig_bank_chk.sv
module irq_elig_bank_chk #(
    parameter int LANES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] req_latch,
    input logic [LANES-1:0] trig_edge,
    input logic [LANES-1:0] line_lvl,
    input logic [LANES-1:0] irq_en,
    input logic [LANES-1:0] irq_act,
    input logic [LANES-1:0] grp_sel,
    input logic [LANES-1:0] grp_qual,
    input logic             sec_off,
    input logic             gate_g1ns,
    input logic             gate_g1s,
    input logic             gate_g0,
    input logic [LANES-1:0] elig_mask
);
    AST_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((elig_mask & ~($past(req_latch) | (~$past(trig_edge) & $past(line_lvl)))) == '0)); // R3
    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((elig_mask & ~$past(irq_en)) == '0)); // R4
    AST_ACTIVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((elig_mask & $past(irq_act)) == '0)); // R5
    AST_G1NS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_g1ns |=> ((elig_mask & $past(grp_sel)) == '0)); // R6
    AST_G1S_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_g1s && !sec_off) |=> ((elig_mask & ~$past(grp_sel) & $past(grp_qual)) == '0)); // R7
    AST_G0_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_g0 && !sec_off) |=> ((elig_mask & ~$past(grp_sel) & ~$past(grp_qual)) == '0)); // R8
    AST_SEC_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_g0 && sec_off) |=> ((elig_mask & ~$past(grp_sel)) == '0)); // R9
endmodule

bind irq_elig_bank irq_elig_bank_chk #(.LANES(LANES)) i_chk (.*);

// File: tb/test_irq_elig_bank.sv
`timescale 1ns/1ps
module test_irq_elig_bank;
    localparam int L = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [L-1:0] lp, ed, lv, en, ac, gr, gm;
    logic         sd, g1ns, g1s, g0;
    logic [L-1:0] mask;
    int           n_vec = 0;
    int           n_bad = 0;

    always #2.5 clk = ~clk;

    irq_elig_bank #(.LANES(L)) i_irq_elig_bank (
        .clk(clk), .rst_n(rst_n),
        .req_latch(lp), .trig_edge(ed), .line_lvl(lv),
        .irq_en(en), .irq_act(ac), .grp_sel(gr), .grp_qual(gm),
        .sec_off(sd), .gate_g1ns(g1ns), .gate_g1s(g1s), .gate_g0(g0),
        .elig_mask(mask)
    );

    function automatic logic [L-1:0] model();
        logic [L-1:0] c, q, g;
        c = (lp | (~ed & lv)) & en & ~ac;
        q = sd ? '0 : gm;
        g = '0;
        if (g1ns) g |= gr;
        if (g1s)  g |= ~gr & q;
        if (g0)   g |= ~gr & ~q;
        return c & g;
    endfunction

    task automatic check(input string tag, input logic [L-1:0] exp);
        n_vec++;
        if (mask !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, mask, exp);
        end
    endtask

    // drive at falling edge, capture at next rising edge, sample 1ns later
    task automatic step(input string tag, input logic [L-1:0] exp);
        @(negedge clk);
        @(posedge clk);
        #1;
        check(tag, exp);
    endtask

    task automatic base();
        lp = '0; ed = '1; lv = '0; en = '1; ac = '0; gr = '1; gm = '0;
        sd = 1'b0; g1ns = 1'b1; g1s = 1'b1; g0 = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        base(); lp = '1; rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 reset", '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_latch();
        @(negedge clk); base(); lp = 32'hA5A5_0001;
        step("R2 latch", 32'hA5A5_0001);
    endtask

    task automatic t_level();
        @(negedge clk); base(); ed = 32'hFFFF_0000; lv = 32'h00FF_00FF;
        step("R3 level/edge", 32'h0000_00FF);
    endtask

    task automatic t_enable();
        @(negedge clk); base(); lp = '1; en = 32'h0F0F_F0F0;
        step("R4 enable", 32'h0F0F_F0F0);
    endtask

    task automatic t_active();
        @(negedge clk); base(); lp = '1; ac = 32'h8000_0001;
        step("R5 active", 32'h7FFF_FFFE);
    endtask

    task automatic t_groups();
        // lanes 31:16 grp1ns, 15:8 secure grp1, 7:0 grp0
        @(negedge clk); base(); lp = '1; gr = 32'hFFFF_0000; gm = 32'h0000_FF00;
        g1ns = 1'b0;
        step("R6 g1ns closed", 32'h0000_FFFF);
        @(negedge clk); g1ns = 1'b1; g1s = 1'b0;
        step("R7 g1s closed", 32'hFFFF_00FF);
        @(negedge clk); g1s = 1'b1; g0 = 1'b0;
        step("R8 g0 closed", 32'hFFFF_FF00);
    endtask

    task automatic t_secoff();
        @(negedge clk); base(); lp = '1; gr = 32'hFFFF_0000; gm = 32'h0000_FF00;
        sd = 1'b1; g1s = 1'b1; g0 = 1'b0;
        step("R9 collapse g0 off", 32'hFFFF_0000);
        @(negedge clk); g1s = 1'b0; g0 = 1'b1;
        step("R9 collapse g1s ignored", 32'hFFFF_FFFF);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            {sd, g1ns, g1s, g0} = 4'(k);
            gr = 32'hF0F0_3C3C; gm = 32'hCC33_AA55;
            lp = 32'h5555_FFFF; ed = 32'h0000_FFFF; lv = 32'hFFFF_0000;
            step("R9 ctl sweep", model());
        end
    endtask

    task automatic t_lanes();
        for (int k = 0; k < L; k++) begin
            @(negedge clk); base(); lp = 32'h1 << k;
            step("R10 walking one", 32'h1 << k);
        end
        @(negedge clk); base();
        lp = 32'hAAAA_AAAA; en = 32'h5555_FFFF; ac = 32'h0000_0F0F;
        gr = 32'h3333_3333; gm = 32'h0F0F_0F0F; g0 = 1'b0;
        step("R10 mixed", model());
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        base();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", '0);
        @(negedge clk); rst_n = 1'b1;
        t_latch();
        t_level();
        t_enable();
        t_active();
        t_groups();
        t_secoff();
        t_lanes();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule